// File: doc/BRIEF.md
# Master Clock Source Selector

This block picks the master tick from one of four tick sources (slow, main, PLL A, PLL B) and divides the chosen stream by a power of two. Every source enters as a single-cycle tick-enable strobe in one system clock domain. The result leaves as a master tick-enable strobe. A one-word control register, written through a simple write strobe, holds a source field and a divider field.

A ready output tells software when the last setting has taken full effect. Any write that alters a field drops ready. The block then waits for two strobes of the newly chosen source. During that wait it emits no master strobe, so no shortened period can appear at a switch. It then restarts the divider from a clean phase and raises ready.

If the chosen PLL reports loss of lock, the block runs from the slow source and holds ready low. When lock comes back, the block returns to the PLL through the same settling wait. Software may order its writes either way: divider first and then source, or source first and then divider. The output is correct after each write.

Top module: `mclk_switch`

## Requirements
- R1: The control word carries the source code in bits [1:0] and the divider code in bits [6:4]. Source code 0 selects slow, 1 selects main, 2 selects PLL A and 3 selects PLL B. All other bits are ignored.
- R2: For divider codes 0 to 6, exactly one master strobe is produced per 2^code strobes of the active source. Each master strobe appears one cycle after the source strobe that completes the count.
- R3: Divider code 7 divides by 1.
- R4: A write that changes the source field, the divider field or both makes ready low in the cycle after the write.
- R5: A write that leaves both fields unchanged keeps ready high.
- R6: While PLL A or PLL B is selected and its lock input is low, ready is low. In that state the master strobe is derived from the slow source through the programmed divider.
- R7: When the lock input of the selected PLL returns high, the master strobe is taken from that PLL again and ready rises after settling.
- R8: After any change of the active source or divider, ready rises in the cycle after the second strobe of the active source, counted from the cycle after the change. No master strobe is produced before that. The divider then restarts from a fresh phase.
- R9: After reset the slow source is selected with division by 1, and ready is high.
- R10: Writing 0x01 and then 0x11 yields the main source divided by 1 and then by 2. Setting a PLL's divider before its source gives the same result as the opposite order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | DATA_W | Control word value |
| slow_tick | input | 1 | Slow source tick enable |
| main_tick | input | 1 | Main source tick enable |
| plla_tick | input | 1 | PLL A tick enable |
| pllb_tick | input | 1 | PLL B tick enable |
| plla_lock | input | 1 | PLL A lock indication |
| pllb_lock | input | 1 | PLL B lock indication |
| mck_tick | output | 1 | Master tick enable |
| mck_ready | output | 1 | Setting in effect |

## Verification
The hardest situation to reach is loss of lock on the PLL that is currently selected. The block must then fall back to the slow source, settle on it and keep dividing, and later settle back onto the PLL. The stimulus selects PLL A with a divider of 2 and lowers its lock input one cycle after a clock edge. It then counts slow strobes and master strobes from the cycle after the fallback takes effect, and restores lock to confirm the settling wait and the divide ratio on the PLL. A full sweep over all 32 source and divider pairs, with each source ticking at its own period, checks the ratio and the two-strobe settling after every write.

// File: rtl/mclk_pkg.sv
// Shared types and helpers for the master clock selector.
// Assumes a two-bit source code and that PLL sources fall back to slow.
package mclk_pkg;

    typedef enum logic [1:0] {
        SRC_SLOW = 2'd0,
        SRC_MAIN = 2'd1,
        SRC_PLLA = 2'd2,
        SRC_PLLB = 2'd3
    } src_e;

    // Source actually in use, given the programmed one and the lock inputs.
    function automatic src_e active_src(input src_e prog, input logic lock_a, input logic lock_b);
        if ((prog == SRC_PLLA && !lock_a) || (prog == SRC_PLLB && !lock_b))
            return SRC_SLOW;
        return prog;
    endfunction

endpackage

// File: rtl/mclk_ctrl_reg.sv
// Control word register: holds the source and divider codes.
// Flags a write that alters either field and exposes the next source code.
// Assumes the two fields do not overlap inside the write word.
module mclk_ctrl_reg
    import mclk_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int SRC_LSB  = 0,
    parameter int PRES_LSB = 4,
    parameter int PRES_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output src_e              src_q,
    output logic [PRES_W-1:0] pres_q,
    output src_e              src_nxt,
    output logic              wr_change
);
    localparam logic [DATA_W-1:0] FIELD_MASK =
        (DATA_W'(3) << SRC_LSB) | (DATA_W'((1 << PRES_W) - 1) << PRES_LSB);

    src_e              src_field;
    logic [PRES_W-1:0] pres_field;
    logic [DATA_W-1:0] spare_unused;

    // Field extraction and change detection for the incoming write.
    always_comb begin
        src_field    = src_e'(wr_data[SRC_LSB +: 2]);
        pres_field   = wr_data[PRES_LSB +: PRES_W];
        wr_change    = wr_en && ((src_field != src_q) || (pres_field != pres_q));
        src_nxt      = wr_change ? src_field : src_q;
        spare_unused = wr_data & ~FIELD_MASK;
    end

    // Register update: only writes that alter a field are taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q  <= SRC_SLOW;
            pres_q <= '0;
        end else if (wr_change) begin
            src_q  <= src_field;
            pres_q <= pres_field;
        end
    end

endmodule

// File: rtl/mclk_src_mux.sv
// Chooses the active tick source, applying slow fallback for an unlocked PLL.
// Raises a restart whenever the active source or a field changes.
// Assumes tick vector order slow, main, PLL A, PLL B (index = source code).
module mclk_src_mux
    import mclk_pkg::*;
#(
    parameter int NUM_SRC = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  src_e               src_q,
    input  src_e               src_nxt,
    input  logic               wr_change,
    input  logic               lock_a,
    input  logic               lock_b,
    input  logic [NUM_SRC-1:0] src_ticks,
    output logic               sel_tick,
    output logic               fallback,
    output logic               restart
);
    src_e act_now;
    src_e act_q;

    // Active source selection and restart generation.
    always_comb begin
        act_now  = active_src(src_q, lock_a, lock_b);
        sel_tick = src_ticks[act_now];
        fallback = (act_now != src_q);
        restart  = wr_change || (act_now != act_q);
    end

    // Track the source expected in the next cycle so a write restarts only once.
    always_ff @(posedge clk) begin
        if (!rst_n) act_q <= SRC_SLOW;
        else        act_q <= active_src(src_nxt, lock_a, lock_b);
    end

endmodule

// File: rtl/mclk_divider.sv
// Settling counter and power-of-two divider on the active tick stream.
// Waits SETTLE_TICKS source ticks after a restart before counting.
// Assumes codes above MAX_CODE mean division by one.
module mclk_divider #(
    parameter int PRES_W       = 3,
    parameter int MAX_CODE     = 6,
    parameter int SETTLE_TICKS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              sel_tick,
    input  logic [PRES_W-1:0] pres_q,
    output logic              settled,
    output logic              tick_out
);
    localparam int CNT_W = (MAX_CODE > 0) ? MAX_CODE : 1;
    localparam int SET_W = $clog2(SETTLE_TICKS + 1);

    logic [SET_W-1:0] settle_cnt;
    logic [CNT_W-1:0] div_cnt;
    logic [CNT_W-1:0] limit;
    logic [CNT_W:0]   pow2;
    logic             wrap;

    // Terminal count derived from the divider code.
    always_comb begin
        pow2 = (CNT_W + 1)'(1) << pres_q;
        if (int'(pres_q) > MAX_CODE) limit = '0;
        else                         limit = CNT_W'(pow2 - 1'b1);
        settled = (settle_cnt == SET_W'(SETTLE_TICKS));
        wrap    = (div_cnt == limit);
    end

    // Settling count of source ticks after a restart.
    always_ff @(posedge clk) begin
        if (!rst_n)                    settle_cnt <= SET_W'(SETTLE_TICKS);
        else if (restart)              settle_cnt <= '0;
        else if (sel_tick && !settled) settle_cnt <= settle_cnt + 1'b1;
    end

    // Divider phase counter, cleared on restart.
    always_ff @(posedge clk) begin
        if (!rst_n || restart)         div_cnt <= '0;
        else if (settled && sel_tick)  div_cnt <= wrap ? '0 : div_cnt + 1'b1;
    end

    // Registered master strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) tick_out <= 1'b0;
        else        tick_out <= !restart && settled && sel_tick && wrap;
    end

endmodule

// File: rtl/mclk_switch.sv
// Master clock selector top: control register, source mux and divider.
// All sources are tick enables in the clk domain; ready reflects a settled,
// locked selection.
module mclk_switch
    import mclk_pkg::*;
#(
    parameter int DATA_W       = 8,
    parameter int SRC_LSB      = 0,
    parameter int PRES_LSB     = 4,
    parameter int PRES_W       = 3,
    parameter int MAX_CODE     = 6,
    parameter int SETTLE_TICKS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              slow_tick,
    input  logic              main_tick,
    input  logic              plla_tick,
    input  logic              pllb_tick,
    input  logic              plla_lock,
    input  logic              pllb_lock,
    output logic              mck_tick,
    output logic              mck_ready
);
    src_e              src_q;
    src_e              src_nxt;
    logic [PRES_W-1:0] pres_q;
    logic              wr_change;
    logic              sel_tick;
    logic              fallback;
    logic              restart;
    logic              settled;

    mclk_ctrl_reg #(
        .DATA_W(DATA_W), .SRC_LSB(SRC_LSB), .PRES_LSB(PRES_LSB), .PRES_W(PRES_W)
    ) u_reg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .src_q(src_q), .pres_q(pres_q), .src_nxt(src_nxt), .wr_change(wr_change)
    );

    mclk_src_mux #(.NUM_SRC(4)) u_mux (
        .clk(clk), .rst_n(rst_n), .src_q(src_q), .src_nxt(src_nxt),
        .wr_change(wr_change), .lock_a(plla_lock), .lock_b(pllb_lock),
        .src_ticks({pllb_tick, plla_tick, main_tick, slow_tick}),
        .sel_tick(sel_tick), .fallback(fallback), .restart(restart)
    );

    mclk_divider #(
        .PRES_W(PRES_W), .MAX_CODE(MAX_CODE), .SETTLE_TICKS(SETTLE_TICKS)
    ) u_div (
        .clk(clk), .rst_n(rst_n), .restart(restart), .sel_tick(sel_tick),
        .pres_q(pres_q), .settled(settled), .tick_out(mck_tick)
    );

    // Ready: settled, not in fallback and no restart pending.
    always_comb mck_ready = settled && !fallback && !restart;

endmodule

// File: rtl/mclk_switch_chk.sv
// Property checker for the master clock selector, bound to the top module.
// Observes ports plus the programmed fields, active tick and settled state.
module mclk_switch_chk #(
    parameter int DATA_W   = 8,
    parameter int SRC_LSB  = 0,
    parameter int PRES_LSB = 4,
    parameter int PRES_W   = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic              plla_lock,
    input logic              pllb_lock,
    input logic              mck_tick,
    input logic              mck_ready,
    input logic [1:0]        src_q,
    input logic [PRES_W-1:0] pres_q,
    input logic              sel_tick,
    input logic              settled
);
    logic alters;
    // Does the current write alter either field.
    always_comb alters = wr_en && ((wr_data[SRC_LSB +: 2] != src_q) ||
                                   (wr_data[PRES_LSB +: PRES_W] != pres_q));

    AST_CHANGE_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        alters |=> !mck_ready); // R4
    AST_UNLOCKED_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        ((src_q == 2'd2 && !plla_lock) || (src_q == 2'd3 && !pllb_lock)) |-> !mck_ready); // R6
    AST_TICK_FROM_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        mck_tick |-> $past(sel_tick)); // R2
    AST_SILENT_WHILE_SETTLING: assert property (@(posedge clk) disable iff (!rst_n)
        !settled |=> !mck_tick); // R8
    AST_READY_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mck_ready) |-> $past(sel_tick)); // R8

endmodule

bind mclk_switch mclk_switch_chk #(
    .DATA_W(DATA_W), .SRC_LSB(SRC_LSB), .PRES_LSB(PRES_LSB), .PRES_W(PRES_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .plla_lock(plla_lock), .pllb_lock(pllb_lock), .mck_tick(mck_tick),
    .mck_ready(mck_ready), .src_q(src_q), .pres_q(pres_q),
    .sel_tick(sel_tick), .settled(settled)
);

// File: tb/mclk_switch_bench.sv
// Bench: sweeps every source/divider pair with sources ticking at distinct
// periods, and exercises PLL lock loss and recovery.
module mclk_switch_bench;
    localparam int WIN = 128;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [3:0] tk = '0;
    logic       lock_a = 1'b1;
    logic       lock_b = 1'b1;
    logic       mck_tick;
    logic       mck_ready;
    int         checks = 0;
    int         errors = 0;
    int         ph [4] = '{0, 0, 0, 0};
    int         per [4] = '{7, 3, 2, 5};
    logic [7:0] cur_word = 8'h00;

    always #10 clk = ~clk;

    mclk_switch u_mclk_switch (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .slow_tick(tk[0]), .main_tick(tk[1]), .plla_tick(tk[2]), .pllb_tick(tk[3]),
        .plla_lock(lock_a), .pllb_lock(lock_b),
        .mck_tick(mck_tick), .mck_ready(mck_ready)
    );

    // Source tick generator: each source strobes at its own period.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            for (int i = 0; i < 4; i++) begin
                ph[i] = (ph[i] + 1) % per[i];
                tk[i] = (ph[i] == 0);
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_word(input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
    endtask

    // Starting at the current negedge, wait for ready; count active ticks.
    task automatic settle_check(input int src, input string req);
        int n = 0;
        int bad = 0;
        int guard = 0;
        while (!mck_ready && guard < 3000) begin
            if (mck_tick) bad++;
            if (tk[src]) n++;
            @(negedge clk);
            guard++;
        end
        chk(bad == 0, req, bad, 0);
        chk(n == 2 && mck_ready, req, n, 2);
    endtask

    // From the current negedge, count output strobes over WIN active ticks.
    task automatic measure(input int src, input int expv, input string req);
        int n = 0;
        int o = 0;
        forever begin
            if (tk[src]) n++;
            if (mck_tick) o++;
            if (n == WIN) break;
            @(negedge clk);
        end
        @(negedge clk);
        if (mck_tick) o++;
        chk(o == expv, req, o, expv);
    endtask

    task automatic apply(input logic [7:0] d, input string req);
        int s = int'(d[1:0]);
        int p = int'(d[6:4]);
        int sh = (p == 7) ? 0 : p;
        bit same = (d[1:0] == cur_word[1:0]) && (d[6:4] == cur_word[6:4]);
        write_word(d);
        cur_word = d;
        @(negedge clk);
        if (same) begin
            chk(mck_ready == 1'b1, "R5 unchanged write keeps ready", int'(mck_ready), 1);
        end else begin
            chk(mck_ready == 1'b0, "R4 ready drops after change", int'(mck_ready), 0);
            settle_check(s, "R8 settle after write");
        end
        measure(s, WIN >> sh, req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state is slow source, divide by 1, ready high
        chk(mck_ready == 1'b1, "R9 ready after reset", int'(mck_ready), 1);
        measure(0, WIN, "R9 slow undivided after reset");
        // R5: identical write first, then the full sweep (R1, R2, R3)
        for (int s = 0; s < 4; s++) begin
            for (int p = 0; p < 8; p++) begin
                apply(8'((p << 4) | s), (p == 7) ? "R3 code 7 divides by 1" : "R1 R2 source and ratio");
            end
        end
        // R10: source first then divider for main; divider first then source for PLL
        apply(8'h01, "R10 main undivided");
        apply(8'h11, "R10 main divided by 2");
        apply(8'h30, "R10 divider staged before PLL");
        apply(8'h32, "R10 PLL A divided by 8");
        apply(8'h12, "R10 PLL A divided by 2");
        // R6: lose lock on selected PLL A
        @(posedge clk);
        #1 lock_a = 1'b0;
        @(negedge clk);
        chk(mck_ready == 1'b0, "R6 ready low on unlock", int'(mck_ready), 0);
        @(posedge clk);
        @(negedge clk);
        begin
            int n = 0;
            int o = 0;
            int hi = 0;
            forever begin
                if (mck_ready) hi++;
                if (tk[0]) n++;
                if (mck_tick) o++;
                if (n == 58) break;
                @(negedge clk);
            end
            @(negedge clk);
            if (mck_tick) o++;
            chk(hi == 0, "R6 ready stays low while unlocked", hi, 0);
            chk(o == 28, "R6 slow fallback divided by 2", o, 28);
        end
        // R7: lock returns
        @(posedge clk);
        #1 lock_a = 1'b1;
        @(posedge clk);
        @(negedge clk);
        settle_check(2, "R7 R8 settle after relock");
        measure(2, WIN >> 1, "R7 PLL A restored divided by 2");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule